// File: doc/BRIEF.md
# Two-Part Serial Data Frame Shifter

This block turns one outgoing data frame into a serial bit stream. The frame is built from two 16-bit words, a low half and a high half. Each half has its own active phase whose length, 0 to 16 bits, comes from a count input. Each phase can also begin with a single logic-0 selection bit. The low phase always goes first and the high phase second. Bits within a phase leave least-significant first. When the high count is zero, the whole high phase is dropped, and so is its selection bit.

A single-cycle `start` strobe captures both data words and all configuration inputs, and the frame then runs from those captured values. The start strobe has no back-pressure. A strobe that arrives while `busy` is high is dropped, and so is a strobe that arrives while `cfg_err` flags a count above 16. A source must wait for `busy` low, or for the `done` pulse, before it offers the next frame.

The frame advances one bit per `shift_en` pulse. `shift_en` comes from an external shift-clock divider. Throughout every bit time, `frame_en` is high and `sdo` carries the current bit.

Top module: `frame_shifter`

## Requirements
- R1: After an accepted start, the first bit is on `sdo` in the next cycle. Each cycle with `shift_en` high moves to the next bit, in this order: the low phase, then the high phase. Without `shift_en`, the current bit is held.
- R2: A low count n (0..16) sends low-data bits 0 through n-1, bit 0 first. A count of 0 sends no low data bits.
- R3: A high count n (1..16) sends high-data bits 0 through n-1, bit 0 first.
- R4: When `lo_sel_en` is 1, one logic-0 bit precedes the low data bits. When `lo_sel_en` is 0 there is no such bit. When `lo_sel_en` is 1 and the low count is 0, the low phase is that one 0 bit.
- R5: When `hi_sel_en` is 1 and the high count is nonzero, one logic-0 bit precedes the high data bits.
- R6: A high count of 0 drops the high phase entirely, and no selection bit is sent even if `hi_sel_en` is 1.
- R7: `cfg_err` is high whenever either count input exceeds 16. A start strobe seen while `cfg_err` is high starts no frame and gives no `done` pulse.
- R8: `frame_en` is high for every bit time of a frame, including selection bits, and low otherwise. `sdo` is low whenever `frame_en` is low.
- R9: `done` is high for exactly one cycle, the cycle after the clock edge that takes in the last bit's `shift_en`. `busy` falls in that same cycle.
- R10: Data and configuration are captured at the accepted start and are then free to change. A start strobe while `busy` is high is ignored.
- R11: A frame with zero bit times (low count 0, `lo_sel_en` 0, high count 0) pulses `done` in the cycle after the start. `busy` stays low and `frame_en` never rises.
- R12: After reset, `busy`, `done`, `frame_en` and `sdo` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start strobe |
| lo_data | input | 16 | Low half data word |
| hi_data | input | 16 | High half data word |
| lo_count | input | 5 | Number of low bits to send (0..16) |
| hi_count | input | 5 | Number of high bits to send (0..16) |
| lo_sel_en | input | 1 | Insert a 0 selection bit before the low phase |
| hi_sel_en | input | 1 | Insert a 0 selection bit before the high phase |
| shift_en | input | 1 | Bit-time advance pulse |
| sdo | output | 1 | Serial data out |
| frame_en | output | 1 | High during every bit time of a frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| cfg_err | output | 1 | A count input is above 16 |

## Verification
The embedded assertions check five properties on every cycle. The current bit position holds while `shift_en` is low. `done` lasts one cycle and never overlaps `busy`. Selection bits drive `sdo` low. `sdo` stays low while `frame_en` is low. A start with a bad count starts nothing. The contents and order of the bit stream can only be shown by the bench's scenarios, which compare every bit time against a scoreboard. Those scenarios cover both halves at full length, both selection bits, a low phase made of only its selection bit, a dropped high phase, a zero-length frame, out-of-range counts, and a start strobe with changed inputs in the middle of a frame.

// File: rtl/frame_pkg.sv
package frame_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LSEL = 3'd1,
    PH_LDAT = 3'd2,
    PH_HSEL = 3'd3,
    PH_HDAT = 3'd4
  } phase_t;
endpackage

// File: rtl/frame_cfg_check.sv
module frame_cfg_check #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [CNT_W-1:0] lo_count,
  input  logic [CNT_W-1:0] hi_count,
  output logic             err
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DATA_W);

  always_comb begin
    err = (lo_count > MAX_CNT) || (hi_count > MAX_CNT);
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W + 1),
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] lo_data,
  input  logic [DATA_W-1:0] hi_data,
  input  logic [CNT_W-1:0]  lo_count,
  input  logic [CNT_W-1:0]  hi_count,
  input  logic              lo_sel_en,
  input  logic              hi_sel_en,
  input  logic              shift_en,
  output phase_t            phase,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] hi_q,
  output logic              done
);
  logic [CNT_W-1:0] lc_q, hc_q;
  logic             ls_q, hs_q;
  phase_t           nxt_phase;
  logic [IDX_W-1:0] nxt_idx;
  logic [CNT_W-1:0] idx_inc;
  phase_t           load_phase;

  function automatic phase_t high_entry(input logic [CNT_W-1:0] hc, input logic hs);
    if (hc == '0)  return PH_IDLE;
    else if (hs)   return PH_HSEL;
    else           return PH_HDAT;
  endfunction

  function automatic phase_t low_entry(input logic [CNT_W-1:0] lc, input logic ls,
                                       input logic [CNT_W-1:0] hc, input logic hs);
    if (ls)             return PH_LSEL;
    else if (lc != '0)  return PH_LDAT;
    else                return high_entry(hc, hs);
  endfunction

  assign idx_inc    = CNT_W'(idx) + CNT_W'(1);
  assign load_phase = low_entry(lo_count, lo_sel_en, hi_count, hi_sel_en);

  always_comb begin
    nxt_phase = phase;
    nxt_idx   = '0;
    unique case (phase)
      PH_LSEL: nxt_phase = (lc_q != '0) ? PH_LDAT : high_entry(hc_q, hs_q);
      PH_LDAT: begin
        if (idx_inc < lc_q) begin
          nxt_idx = idx + IDX_W'(1);
        end else begin
          nxt_phase = high_entry(hc_q, hs_q);
        end
      end
      PH_HSEL: nxt_phase = PH_HDAT;
      PH_HDAT: begin
        if (idx_inc < hc_q) begin
          nxt_idx = idx + IDX_W'(1);
        end else begin
          nxt_phase = PH_IDLE;
        end
      end
      default: nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      lc_q  <= '0;
      hc_q  <= '0;
      ls_q  <= 1'b0;
      hs_q  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (load) begin
          lo_q  <= lo_data;
          hi_q  <= hi_data;
          lc_q  <= lo_count;
          hc_q  <= hi_count;
          ls_q  <= lo_sel_en;
          hs_q  <= hi_sel_en;
          phase <= load_phase;
          idx   <= '0;
          done  <= (load_phase == PH_IDLE);
        end
      end else if (shift_en) begin
        phase <= nxt_phase;
        idx   <= nxt_idx;
        done  <= (nxt_phase == PH_IDLE);
      end
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !shift_en) |=> ($stable(phase) && $stable(idx)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/frame_bit_sel.sv
module frame_bit_sel
  import frame_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  phase_t            phase,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] lo_q,
  input  logic [DATA_W-1:0] hi_q,
  output logic              sdo,
  output logic              frame_en
);
  always_comb begin
    unique case (phase)
      PH_LDAT: sdo = lo_q[idx];
      PH_HDAT: sdo = hi_q[idx];
      default: sdo = 1'b0;
    endcase
    frame_en = (phase != PH_IDLE);
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import frame_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] lo_data,
  input  logic [DATA_W-1:0] hi_data,
  input  logic [CNT_W-1:0]  lo_count,
  input  logic [CNT_W-1:0]  hi_count,
  input  logic              lo_sel_en,
  input  logic              hi_sel_en,
  input  logic              shift_en,
  output logic              sdo,
  output logic              frame_en,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);
  phase_t            phase;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] lo_q, hi_q;
  logic              load;

  frame_cfg_check #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cfg (
    .lo_count (lo_count),
    .hi_count (hi_count),
    .err      (cfg_err)
  );

  assign busy = (phase != PH_IDLE);
  assign load = start && !busy && !cfg_err;

  frame_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .lo_data   (lo_data),
    .hi_data   (hi_data),
    .lo_count  (lo_count),
    .hi_count  (hi_count),
    .lo_sel_en (lo_sel_en),
    .hi_sel_en (hi_sel_en),
    .shift_en  (shift_en),
    .phase     (phase),
    .idx       (idx),
    .lo_q      (lo_q),
    .hi_q      (hi_q),
    .done      (done)
  );

  frame_bit_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bit (
    .phase    (phase),
    .idx      (idx),
    .lo_q     (lo_q),
    .hi_q     (hi_q),
    .sdo      (sdo),
    .frame_en (frame_en)
  );

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_en |-> !sdo);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_bad_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cfg_err) |=> (!busy && !done));

  assert_sel_bit_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LSEL || phase == PH_HSEL) |-> !sdo);
endmodule

// File: tb/test_frame_shifter.sv
module test_frame_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] lo_data = '0, hi_data = '0;
  logic [4:0]  lo_count = '0, hi_count = '0;
  logic        lo_sel_en = 1'b0, hi_sel_en = 1'b0;
  logic        shift_en = 1'b0;
  logic        sdo, frame_en, busy, done, cfg_err;

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  bit finished = 1'b0;
  bit exp_q[$];

  always #2 clk = ~clk;

  frame_shifter i_frame_shifter (
    .clk(clk), .rst_n(rst_n), .start(start),
    .lo_data(lo_data), .hi_data(hi_data),
    .lo_count(lo_count), .hi_count(hi_count),
    .lo_sel_en(lo_sel_en), .hi_sel_en(hi_sel_en),
    .shift_en(shift_en), .sdo(sdo), .frame_en(frame_en),
    .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compares each bit time against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (frame_en && shift_en) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected bit time", 1, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          check(sdo == e, "R1 serial bit", int'(sdo), int'(e));
        end
      end
      if (done) done_cnt++;
    end
  end

  // Driver: pushes the expected stream, then runs the frame
  task automatic run_frame(input logic [15:0] lo, input logic [15:0] hi,
                           input int lc, input int hc, input bit ls, input bit hs,
                           input int gap, input int poke, input string tag);
    int n;
    int d0;
    n = 0;
    if (ls) begin exp_q.push_back(1'b0); n++; end
    for (int i = 0; i < lc; i++) begin exp_q.push_back(lo[i]); n++; end
    if (hc != 0) begin
      if (hs) begin exp_q.push_back(1'b0); n++; end
      for (int i = 0; i < hc; i++) begin exp_q.push_back(hi[i]); n++; end
    end
    d0 = done_cnt;
    @(posedge clk); #1;
    lo_data = lo; hi_data = hi; lo_count = 5'(lc); hi_count = 5'(hc);
    lo_sel_en = ls; hi_sel_en = hs; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (n == 0) begin
      check(done == 1'b1, {tag, " R11 done after empty start"}, int'(done), 1);
      check(busy == 1'b0, {tag, " R11 busy stays low"}, int'(busy), 0);
      check(frame_en == 1'b0, {tag, " R11 frame_en low"}, int'(frame_en), 0);
    end else begin
      for (int i = 0; i < n; i++) begin
        repeat (gap) begin
          @(posedge clk); #1;
        end
        shift_en = 1'b1;
        if (i == poke) begin
          // R10: change every input and strobe start mid-frame
          start = 1'b1;
          lo_data = ~lo; hi_data = ~hi; lo_count = 5'd2; hi_count = 5'd1;
          lo_sel_en = ~ls; hi_sel_en = ~hs;
        end
        check(frame_en && busy, {tag, " R8 frame_en during bit time"}, int'(frame_en), 1);
        @(posedge clk); #1;
        shift_en = 1'b0;
        start = 1'b0;
      end
      check(done == 1'b1, {tag, " R9 done after last bit"}, int'(done), 1);
      check(busy == 1'b0, {tag, " R9 busy falls with done"}, int'(busy), 0);
      check(exp_q.size() == 0, {tag, " R2 R3 all bits seen"}, exp_q.size(), 0);
    end
    @(posedge clk); #1;
    check(done == 1'b0, {tag, " R9 done one cycle"}, int'(done), 0);
    check(done_cnt == d0 + 1, {tag, " R10 single done"}, done_cnt - d0, 1);
    repeat (3) @(posedge clk);
    #1;
    check(frame_en == 1'b0 && sdo == 1'b0, {tag, " R8 idle low"}, int'(frame_en), 0);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !done && !frame_en && !sdo, "R12 reset state",
          int'({busy, done, frame_en, sdo}), 0);
    rst_n = 1'b1;

    run_frame(16'hA5C3, 16'h3C5A, 16, 16, 1'b0, 1'b0, 0, -1, "full");
    run_frame(16'h0015, 16'h0005, 5, 3, 1'b1, 1'b1, 2, -1, "R4 R5 sel");
    run_frame(16'hFFFF, 16'hFFFF, 0, 0, 1'b1, 1'b1, 1, -1, "R6 lsel only");
    run_frame(16'hFFFF, 16'h000B, 0, 4, 1'b0, 1'b1, 0, -1, "R5 hi only");
    run_frame(16'h0001, 16'h8001, 1, 16, 1'b0, 1'b0, 3, -1, "R3 one low");
    run_frame(16'h1234, 16'h5678, 16, 0, 1'b1, 1'b1, 0, -1, "R6 no high");
    run_frame(16'hFFFF, 16'hFFFF, 0, 0, 1'b0, 1'b1, 0, -1, "R11 empty");
    run_frame(16'h00C3, 16'h0096, 8, 8, 1'b1, 1'b0, 1, 3, "R10 busy start");

    // R7: out-of-range counts
    @(posedge clk); #1;
    lo_count = 5'd17; hi_count = 5'd4;
    #1;
    check(cfg_err == 1'b1, "R7 cfg_err low count", int'(cfg_err), 1);
    lo_count = 5'd3; hi_count = 5'd31;
    #1;
    check(cfg_err == 1'b1, "R7 cfg_err high count", int'(cfg_err), 1);
    lo_count = 5'd16; hi_count = 5'd16;
    #1;
    check(cfg_err == 1'b0, "R7 cfg_err clear at 16", int'(cfg_err), 0);
    begin
      int d0;
      d0 = done_cnt;
      lo_count = 5'd20; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      check(busy == 1'b0 && frame_en == 1'b0, "R7 bad start ignored", int'(busy), 0);
      repeat (2) @(posedge clk);
      #1;
      check(done_cnt == d0, "R7 no done on bad start", done_cnt - d0, 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule